// File: doc/BRIEF.md
# UART FIFO Control and DMA Ready Signalling

This block holds the transmit and receive byte queues of a 16550-class serial port, together with the control byte that configures them. From the fill levels of the two queues it derives two active-low DMA request lines and two interrupt lines. The host fills the transmit queue and the serializer drains it. The deserializer fills the receive queue and the host or a DMA engine drains it. Serial framing, baud timing, status registers and interrupt prioritisation live elsewhere.

The control byte has these fields:

- bit 0 enables the queues;
- bit 1 flushes the receive queue;
- bit 2 flushes the transmit queue;
- bit 3 picks the signalling mode;
- bit 5 picks the depth;
- bits 7:6 pick the receive trigger.

Bit 4 is ignored. With the queues disabled, each direction holds one character. Mode 0 signals per character. Mode 1 signals in blocks around the trigger level.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After reset, both levels are 0, the queues are disabled, mode 0 and 16-deep are selected, tx_rdy_n=0, rx_rdy_n=1, tx_irq=1, rx_irq=0, and both overrun outputs are 0.
- R2: A write of cfg_data takes effect at the clock edge where cfg_wr is high. The fields are: bit0 enable, bit3 mode (1 selects block mode), bit5 depth (1 selects 64 entries), bits 7:6 trigger code. Bit 4 has no effect, and a write that changes neither bit0 nor bit5 leaves the levels untouched.
- R3: With bit0=0, each queue holds at most one character.
- R4: With bit0=1, each queue holds up to 16 entries (bit5=0) or 64 entries (bit5=1).
- R5: Bytes leave a queue in push order. rdata shows the popped byte from the clock edge of the pop onward.
- R6: A pop from an empty queue leaves the level unchanged and rdata holding its previous value.
- R7: A push to a full queue is dropped, leaves the level unchanged, and raises the overrun output high for exactly the one cycle after that edge.
- R8: In mode 0, or with the queues disabled, tx_rdy_n is 0 exactly when the transmit level is 0, and tx_irq is its inverse.
- R9: In mode 0, or with the queues disabled, rx_rdy_n is 0 and rx_irq is 1 exactly when the receive level is at least 1.
- R10: In mode 1, rx_irq is 1 and rx_rdy_n is 0 exactly when the receive level is at or above the trigger. The trigger codes 00/01/10/11 give 1/4/8/14 entries at depth 16 and 1/16/32/56 entries at depth 64. The queue keeps filling past the trigger.
- R11: In mode 1, tx_irq is 1 exactly when the transmit level is below the trigger. tx_rdy_n goes 0 when the transmit level is 0 and goes 1 when it is full; between those points it keeps its last value.
- R12: A write with bit1 set empties the receive queue, and a write with bit2 set empties the transmit queue, at that edge. Neither bit is stored, and neither touches the other queue.
- R13: A write that changes bit0 or bit5 empties both queues at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | DATA_W | Transmit byte in |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_rdata | output | DATA_W | Byte taken by the serializer |
| tx_level | output | LVL_W | Transmit fill level |
| tx_overrun | output | 1 | Dropped transmit push pulse |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wdata | input | DATA_W | Received byte in |
| rx_pop | input | 1 | Host or DMA reads a byte |
| rx_rdata | output | DATA_W | Byte read by host |
| rx_level | output | LVL_W | Receive fill level |
| rx_overrun | output | 1 | Dropped receive push pulse |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |
| rx_rdy_n | output | 1 | Active-low receive DMA request |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
On every cycle, the assertions check these properties:

- the levels stay within the selected capacity;
- an overrun pulse only follows a push into a full queue;
- rdata holds across an empty pop;
- the mode-0 receive request follows the level;
- an empty transmit queue always requests and a full one in mode 1 never does;
- flushes and depth changes leave the queues empty on the next cycle.

Only the bench scenarios show the rest:

- the order of data through each queue;
- the trigger table at both depths;
- the mode-1 transmit hysteresis between empty and full;
- that the reserved bit and a mode-only write leave the contents alone.

// File: rtl/ufc_pkg.sv
// Shared types and helpers for the UART FIFO control block.
// Assumes queue depths are powers of two of at least 16.
package ufc_pkg;

    // Stored fields of the control byte; flush bits are not held.
    typedef struct packed {
        logic [1:0] trig;
        logic       deep;
        logic       mode1;
        logic       en;
    } ufc_cfg_t;

    // Receive trigger in entries for a given depth and 2-bit code.
    function automatic int ufc_trig(input int depth, input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/ufc_cfg_reg.sv
// Control byte register. Holds enable, mode, depth and trigger; turns the
// flush bits and any change of enable or depth into one-cycle clear strobes.
// Assumes cfg_data is stable while cfg_wr is high at the clock edge.
module ufc_cfg_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ufc_cfg_t   cfg_q,
    output logic       rx_clr,
    output logic       tx_clr
);

    logic restart;
    logic unused_rsvd;

    assign unused_rsvd = wdata[4];

    // Capture the stored fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= '{trig: wdata[7:6], deep: wdata[5], mode1: wdata[3], en: wdata[0]};
        end
    end

    // Derive the flush strobes, including those forced by a geometry change.
    always_comb begin
        restart = wr && ((wdata[5] != cfg_q.deep) || (wdata[0] != cfg_q.en));
        rx_clr  = (wr && wdata[1]) || restart;
        tx_clr  = (wr && wdata[2]) || restart;
    end

endmodule

// File: rtl/ufc_byte_fifo.sv
// Byte queue with storage for DEPTH entries and a run-time capacity limit.
// A push beyond the limit is dropped and flagged one cycle later. An empty
// pop keeps rdata. Assumes DEPTH is a power of two and cap <= DEPTH.
module ufc_byte_fifo #(
    parameter  int DW    = 8,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          overrun
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          acc_push, acc_pop;

    // Decide which requests are honoured this cycle.
    always_comb begin
        acc_push = push && (level < cap);
        acc_pop  = pop && (level != '0);
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (acc_push && !clr) begin
            mem[wp] <= wdata;
        end
    end

    // Advance pointers, level, read data and the overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            level   <= '0;
            rdata   <= '0;
            overrun <= 1'b0;
        end else if (clr) begin
            wp      <= '0;
            rp      <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (acc_push) wp <= wp + AW'(1);
            if (acc_pop) begin
                rp    <= rp + AW'(1);
                rdata <= mem[rp];
            end
            level   <= level + LW'(acc_push) - LW'(acc_pop);
            overrun <= push && !acc_push;
        end
    end

endmodule

// File: rtl/ufc_ready_logic.sv
// Turns fill levels into DMA requests and interrupts. Per-character
// signalling when blk is low; trigger-based block signalling when high.
// Assumes levels never exceed cap.
module ufc_ready_logic #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk,
    input  logic [LW-1:0] cap,
    input  logic [LW-1:0] trig,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    output logic          tx_rdy_n,
    output logic          rx_rdy_n,
    output logic          tx_irq,
    output logic          rx_irq
);

    logic tx_hold_q;

    // Remember the last transmit request level for block-mode hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_hold_q <= 1'b0;
        else        tx_hold_q <= tx_rdy_n;
    end

    // Select per-character or block signalling.
    always_comb begin
        if (blk) begin
            if (tx_level == '0)      tx_rdy_n = 1'b0;
            else if (tx_level >= cap) tx_rdy_n = 1'b1;
            else                     tx_rdy_n = tx_hold_q;
            tx_irq   = tx_level < trig;
            rx_irq   = rx_level >= trig;
            rx_rdy_n = !(rx_level >= trig);
        end else begin
            tx_rdy_n = tx_level != '0;
            tx_irq   = tx_level == '0;
            rx_irq   = rx_level != '0;
            rx_rdy_n = rx_level == '0;
        end
    end

endmodule

// File: rtl/uart_fifo_dma_ctl.sv
// UART FIFO control top: control byte, two byte queues and the ready/
// interrupt generation. Assumes DEEP_N and SHALLOW_N are powers of two.
module uart_fifo_dma_ctl
    import ufc_pkg::*;
#(
    parameter  int DATA_W    = 8,
    parameter  int DEEP_N    = 64,
    parameter  int SHALLOW_N = 16,
    localparam int LVL_W     = $clog2(DEEP_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [LVL_W-1:0]  tx_level,
    output logic              tx_overrun,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_overrun,
    output logic              tx_rdy_n,
    output logic              rx_rdy_n,
    output logic              tx_irq,
    output logic              rx_irq
);

    ufc_cfg_t         cfg_q;
    logic             rx_clr, tx_clr;
    logic             blk;
    logic             cfg_deep;
    logic [LVL_W-1:0] cap, trig;

    ufc_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_data),
        .cfg_q  (cfg_q),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    // Capacity and trigger for the active configuration.
    always_comb begin
        blk      = cfg_q.en && cfg_q.mode1;
        cfg_deep = cfg_q.deep;
        if (!cfg_q.en)       cap = LVL_W'(1);
        else if (cfg_q.deep) cap = LVL_W'(DEEP_N);
        else                 cap = LVL_W'(SHALLOW_N);
        trig = LVL_W'(ufc_trig(cfg_q.deep ? DEEP_N : SHALLOW_N, cfg_q.trig));
    end

    ufc_byte_fifo #(.DW(DATA_W), .DEPTH(DEEP_N)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .cap     (cap),
        .push    (tx_push),
        .wdata   (tx_wdata),
        .pop     (tx_pop),
        .rdata   (tx_rdata),
        .level   (tx_level),
        .overrun (tx_overrun)
    );

    ufc_byte_fifo #(.DW(DATA_W), .DEPTH(DEEP_N)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .cap     (cap),
        .push    (rx_push),
        .wdata   (rx_wdata),
        .pop     (rx_pop),
        .rdata   (rx_rdata),
        .level   (rx_level),
        .overrun (rx_overrun)
    );

    ufc_ready_logic #(.LW(LVL_W)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk      (blk),
        .cap      (cap),
        .trig     (trig),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_rdy_n (tx_rdy_n),
        .rx_rdy_n (rx_rdy_n),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

endmodule

// File: rtl/ufc_checker.sv
// Cycle-level properties of the UART FIFO control block, bound to the top.
module ufc_checker #(
    parameter int DW = 8,
    parameter int LW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic          wr_rx_flush,
    input logic          wr_deep,
    input logic          cfg_deep,
    input logic          blk,
    input logic [LW-1:0] cap,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          rx_push,
    input logic          rx_pop,
    input logic [DW-1:0] rx_rdata,
    input logic          rx_overrun,
    input logic          tx_rdy_n,
    input logic          rx_rdy_n,
    input logic          rx_irq
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= cap) && (rx_level <= cap)); // R4

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_push) && ($past(rx_level) == $past(cap)))); // R7

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && (rx_level == '0)) |=> $stable(rx_rdata)); // R6

    AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> !tx_rdy_n); // R8

    AST_TX_FULL_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && (tx_level == cap)) |-> tx_rdy_n); // R11

    AST_RX_CHAR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !blk |-> (rx_rdy_n == (rx_level == '0))); // R9

    AST_RX_IRQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == !rx_rdy_n); // R10

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && wr_rx_flush) |=> (rx_level == '0)); // R12

    AST_DEPTH_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (wr_deep != cfg_deep)) |=> ((rx_level == '0) && (tx_level == '0))); // R13

endmodule

bind uart_fifo_dma_ctl ufc_checker #(.DW(DATA_W), .LW(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .wr_rx_flush (cfg_data[1]),
    .wr_deep     (cfg_data[5]),
    .cfg_deep    (cfg_deep),
    .blk         (blk),
    .cap         (cap),
    .tx_level    (tx_level),
    .rx_level    (rx_level),
    .rx_push     (rx_push),
    .rx_pop      (rx_pop),
    .rx_rdata    (rx_rdata),
    .rx_overrun  (rx_overrun),
    .tx_rdy_n    (tx_rdy_n),
    .rx_rdy_n    (rx_rdy_n),
    .rx_irq      (rx_irq)
);

// File: tb/uart_fifo_dma_ctl_test.sv
// Scoreboard bench: driver tasks record expected bytes, monitors compare pops.
module uart_fifo_dma_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_data = '0;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]    tx_wdata = '0, rx_wdata = '0;
    logic [7:0]    tx_rdata, rx_rdata;
    logic [LW-1:0] tx_level, rx_level;
    logic          tx_overrun, rx_overrun, tx_rdy_n, rx_rdy_n, tx_irq, rx_irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] txq[$], rxq[$], tx_exp[$], rx_exp[$];
    logic       m_en = 1'b0, m_deep = 1'b0;
    event       tx_ev, rx_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_dma_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_level(tx_level), .tx_overrun(tx_overrun),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_level(rx_level), .rx_overrun(rx_overrun),
        .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int m_cap();
        return !m_en ? 1 : (m_deep ? 64 : 16);
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        logic restart;
        restart = (v[0] != m_en) || (v[5] != m_deep);
        cfg_wr = 1'b1; cfg_data = v;
        tick();
        cfg_wr = 1'b0;
        if (restart || v[1]) rxq.delete();
        if (restart || v[2]) txq.delete();
        m_en = v[0]; m_deep = v[5];
    endtask

    task automatic rx_put(input logic [7:0] d);
        logic ok;
        ok = rxq.size() < m_cap();
        rx_push = 1'b1; rx_wdata = d;
        tick();
        rx_push = 1'b0;
        if (ok) rxq.push_back(d);
        chk("R7 rx overrun", int'(rx_overrun), int'(!ok));
    endtask

    task automatic tx_put(input logic [7:0] d);
        logic ok;
        ok = txq.size() < m_cap();
        tx_push = 1'b1; tx_wdata = d;
        tick();
        tx_push = 1'b0;
        if (ok) txq.push_back(d);
        chk("R7 tx overrun", int'(tx_overrun), int'(!ok));
    endtask

    task automatic rx_take();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
        if (rxq.size() > 0) begin
            rx_exp.push_back(rxq.pop_front());
            -> rx_ev;
        end
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
        if (txq.size() > 0) begin
            tx_exp.push_back(txq.pop_front());
            -> tx_ev;
        end
    endtask

    // Monitors: compare each popped byte with the scoreboard (R5).
    always @(rx_ev) begin
        chk("R5 rx order", int'(rx_rdata), int'(rx_exp.pop_front()));
    end

    always @(tx_ev) begin
        chk("R5 tx order", int'(tx_rdata), int'(tx_exp.pop_front()));
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 tx_rdy_n", int'(tx_rdy_n), 0);
        chk("R1 rx_rdy_n", int'(rx_rdy_n), 1);
        chk("R1 tx_irq", int'(tx_irq), 1);
        chk("R1 rx_irq", int'(rx_irq), 0);
        chk("R1 overrun", int'(tx_overrun | rx_overrun), 0);

        // Disabled: single holding register per direction
        rx_put(8'hA5);
        chk("R9 rx_rdy_n", int'(rx_rdy_n), 0);
        chk("R9 rx_irq", int'(rx_irq), 1);
        rx_put(8'h3C);
        chk("R3 rx_level", int'(rx_level), 1);
        tick();
        chk("R7 pulse width", int'(rx_overrun), 0);
        rx_take();
        chk("R9 rx_rdy_n empty", int'(rx_rdy_n), 1);
        rx_take();
        chk("R6 rdata hold", int'(rx_rdata), 8'hA5);
        chk("R6 level", int'(rx_level), 0);
        tx_put(8'h11);
        chk("R8 tx_rdy_n", int'(tx_rdy_n), 1);
        chk("R8 tx_irq", int'(tx_irq), 0);
        tx_put(8'h22);
        chk("R3 tx_level", int'(tx_level), 1);
        tx_take();
        chk("R8 tx_rdy_n empty", int'(tx_rdy_n), 0);
        chk("R8 tx_irq empty", int'(tx_irq), 1);

        // Enabled, 16-deep, mode 0
        cfg_write(8'h01);
        chk("R2 enable", int'(rx_level), 0);
        for (int i = 0; i < 20; i++) rx_put(8'(i + 1));
        chk("R4 depth16", int'(rx_level), 16);
        for (int i = 0; i < 16; i++) rx_take();

        // 64-deep
        cfg_write(8'h21);
        for (int i = 0; i < 70; i++) tx_put(8'(8'h40 + i));
        chk("R4 depth64", int'(tx_level), 64);
        cfg_write(8'h01);
        chk("R13 depth change", int'(tx_level), 0);
        chk("R13 tx_rdy_n", int'(tx_rdy_n), 0);
        txq.delete();
        for (int i = 0; i < 3; i++) rx_put(8'(8'h70 + i));
        cfg_write(8'h00);
        chk("R13 enable change", int'(rx_level), 0);
        cfg_write(8'h01);

        // Mode 1, 16-deep, trigger code 10 -> 8
        cfg_write(8'h89);
        tx_put(8'hB1);
        tx_put(8'hB2);
        for (int i = 0; i < 7; i++) rx_put(8'(8'h80 + i));
        chk("R10 below trig irq", int'(rx_irq), 0);
        chk("R10 below trig rdy", int'(rx_rdy_n), 1);
        cfg_write(8'h99);
        chk("R2 reserved bit", int'(rx_level), 7);
        chk("R2 reserved irq", int'(rx_irq), 0);
        rx_put(8'h87);
        chk("R10 at trig irq", int'(rx_irq), 1);
        chk("R10 at trig rdy", int'(rx_rdy_n), 0);
        for (int i = 0; i < 8; i++) rx_put(8'(8'h88 + i));
        chk("R10 fills past trig", int'(rx_level), 16);
        for (int i = 0; i < 8; i++) rx_take();
        chk("R10 still at trig", int'(rx_irq), 1);
        rx_take();
        chk("R10 drop below", int'(rx_rdy_n), 1);
        cfg_write(8'h8B);
        chk("R12 rx flush", int'(rx_level), 0);
        chk("R12 tx untouched", int'(tx_level), 2);
        tx_take();
        tx_take();

        // Mode 1, 64-deep, trigger code 11 -> 56
        cfg_write(8'hE9);
        chk("R13 deep switch", int'(tx_level), 0);
        chk("R11 empty rdy", int'(tx_rdy_n), 0);
        chk("R11 empty irq", int'(tx_irq), 1);
        for (int i = 0; i < 55; i++) tx_put(8'(i));
        chk("R11 below trig irq", int'(tx_irq), 1);
        chk("R11 hold low", int'(tx_rdy_n), 0);
        tx_put(8'd55);
        chk("R11 at trig irq", int'(tx_irq), 0);
        for (int i = 56; i < 64; i++) tx_put(8'(i));
        chk("R11 full rdy", int'(tx_rdy_n), 1);
        tx_take();
        chk("R11 hold high", int'(tx_rdy_n), 1);
        for (int i = 0; i < 62; i++) tx_take();
        chk("R11 hold high at 1", int'(tx_rdy_n), 1);
        tx_take();
        chk("R11 empty again", int'(tx_rdy_n), 0);
        for (int i = 0; i < 3; i++) tx_put(8'(8'hC0 + i));
        chk("R11 hold low at 3", int'(tx_rdy_n), 0);
        cfg_write(8'hED);
        chk("R12 tx flush", int'(tx_level), 0);

        // Trigger code 01 at depth 64 -> 16, then code 00 -> 1
        cfg_write(8'h69);
        for (int i = 0; i < 15; i++) rx_put(8'(8'hD0 + i));
        chk("R10 64 code01 below", int'(rx_irq), 0);
        rx_put(8'hDF);
        chk("R10 64 code01 at", int'(rx_irq), 1);
        cfg_write(8'h29);
        chk("R10 code00", int'(rx_irq), 1);
        for (int i = 0; i < 16; i++) rx_take();
        chk("R10 code00 empty", int'(rx_irq), 0);

        // Mode 1 selected with queues disabled behaves per character
        cfg_write(8'h08);
        rx_put(8'hEE);
        chk("R9 disabled mode1", int'(rx_rdy_n), 0);
        rx_take();

        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule